// File: doc/BRIEF.md
# Bidirectional Preset Counter

This block is a synchronous counter that moves one step per clock, upward or downward, as selected by a single direction input. A parameter builds it either as a full binary counter (modulus 16 at the default width) or as a decade counter (modulus 10). In both directions the count wraps at the ends of its range.

An active-low preset input forces the count to the parallel data value without waiting for a clock, and overrides counting. A terminal flag marks the last state in the current direction, so that a neighbour can detect a full count in either direction. The reset input asserts asynchronously and is released in step with the clock.

Top module: `updown_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0 at once, without a clock edge, even with `load_n` low. After `rst_n` rises, the count stays at 0 for the next two rising clock edges. Counting begins at the third edge.
- R2: With `load_n` high, `cnt_en_n` low and `up_dn` = 1 (up), each rising clock edge raises `q` by one, as long as `q` is below MODULUS-1.
- R3: With `load_n` high, `cnt_en_n` low and `up_dn` = 0 (down), each rising clock edge lowers `q` by one, as long as `q` is not 0.
- R4: In the binary variant (MODULUS = 16), counting up from 15 gives 0, and counting down from 0 gives 15.
- R5: In the decade variant (MODULUS = 10), counting up from 9 gives 0, and counting down from 0 gives 9.
- R6: In the decade variant, a value from 10 to 15 placed by preset goes to 0 on an up step. On a down step it drops by one (13 gives 12).
- R7: While `cnt_en_n` is 1, rising clock edges leave `q` unchanged.
- R8: While `load_n` is low, `q` equals `d` without any clock edge, and follows changes of `d`.
- R9: Preset wins over counting and over the enable. Clock edges while `load_n` is low keep `q` equal to `d`. After `load_n` rises, counting continues from the preset value, provided `d` was held steady over the last edge before release.
- R10: `term_hit` is 1 when `up_dn` = 1 and `q` = MODULUS-1, or when `up_dn` = 0 and `q` = 0. Otherwise it is 0. It follows a change of `up_dn` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_en_n | input | 1 | Count enable, active low |
| load_n | input | 1 | Asynchronous preset, active low |
| d | input | WIDTH (4) | Preset value |
| q | output | WIDTH (4) | Current count |
| term_hit | output | 1 | Terminal count in the current direction |

## Verification
The bench builds two copies side by side: one with WIDTH 4 and MODULUS 16, and one with WIDTH 4 and MODULUS 10. Both receive the same stimulus. This makes the two wrap rules directly comparable: 15 to 0 against 9 to 0, and 0 to 15 against 0 to 9. The shared 4-bit field also lets a preset of 12 or 13 land outside the decade range, which exercises the recovery rule. Preset pulses are timed between clock edges, so that the asynchronous path is observed without a clock edge.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } count_dir_e;

  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/ud_reset_sync.sv
module ud_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/ud_next_count.sv
module ud_next_count
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MODULUS = 16
) (
  input  logic [WIDTH-1:0] cur,
  input  count_dir_e       dir,
  input  logic             step_en,
  output logic [WIDTH-1:0] nxt
);

  localparam int unsigned FULL_RANGE = 1 << WIDTH;

  logic [WIDTH-1:0] stepped;

  generate
    if (MODULUS == FULL_RANGE) begin : g_binary
      always_comb begin
        if (dir == DIR_UP) begin
          stepped = cur + 1'b1;
        end else begin
          stepped = cur - 1'b1;
        end
      end
    end else begin : g_truncated
      localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);
      always_comb begin
        if (dir == DIR_UP) begin
          stepped = (cur >= TOP) ? '0 : cur + 1'b1;
        end else begin
          stepped = (cur == '0) ? TOP : cur - 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    nxt = step_en ? stepped : cur;
  end

endmodule

// File: rtl/ud_count_reg.sv
module ud_count_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n or negedge load_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!load_n) begin
      cnt <= d;
    end else begin
      cnt <= nxt;
    end
  end

endmodule

// File: rtl/ud_terminal.sv
module ud_terminal
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MODULUS = 16
) (
  input  logic [WIDTH-1:0] q,
  input  count_dir_e       dir,
  output logic             term_hit
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  always_comb begin
    if (dir == DIR_UP) begin
      term_hit = (q == TOP);
    end else begin
      term_hit = (q == '0);
    end
  end

endmodule

// File: rtl/updown_counter.sv
module updown_counter
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MODULUS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_dn,
  input  logic             cnt_en_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             term_hit
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  logic             rst_q_n;
  count_dir_e       dir;
  logic             step_en;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] cnt_nxt;

  assign dir     = count_dir_e'(up_dn);
  assign step_en = ~cnt_en_n;

  ud_reset_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ud_next_count #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) u_next (
    .cur     (cnt),
    .dir     (dir),
    .step_en (step_en),
    .nxt     (cnt_nxt)
  );

  ud_count_reg #(
    .WIDTH (WIDTH)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_n (load_n),
    .d      (d),
    .nxt    (cnt_nxt),
    .cnt    (cnt)
  );

  always_comb begin
    if (rst_q_n && !load_n) begin
      q = d;
    end else begin
      q = cnt;
    end
  end

  ud_terminal #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) u_term (
    .q        (q),
    .dir      (dir),
    .term_hit (term_hit)
  );

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n || !load_n)
    (!cnt_en_n && up_dn && q < TOP) |=> (q == WIDTH'($past(q) + 1'b1)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n || !load_n)
    (!cnt_en_n && !up_dn && q != '0) |=> (q == WIDTH'($past(q) - 1'b1)));

  // R4 R5 R6
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n || !load_n)
    (!cnt_en_n && up_dn && q >= TOP) |=> (q == '0));

  // R4 R5
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n || !load_n)
    (!cnt_en_n && !up_dn && q == '0) |=> (q == TOP));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n || !load_n)
    cnt_en_n |=> $stable(q));

  // R10
  term_low_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (q != TOP && q != '0) |-> !term_hit);

endmodule

// File: tb/updown_counter_bench.sv
module updown_counter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_dn;
  logic       cnt_en_n;
  logic       load_n;
  logic [3:0] d;
  logic [3:0] q_bin;
  logic [3:0] q_dec;
  logic       t_bin;
  logic       t_dec;

  int checks = 0;
  int errors = 0;
  int m_bin  = 0;
  int m_dec  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  updown_counter #(.WIDTH(4), .MODULUS(16)) u_updown_counter (
    .clk(clk), .rst_n(rst_n), .up_dn(up_dn), .cnt_en_n(cnt_en_n),
    .load_n(load_n), .d(d), .q(q_bin), .term_hit(t_bin)
  );

  updown_counter #(.WIDTH(4), .MODULUS(10)) u_updown_counter_dec (
    .clk(clk), .rst_n(rst_n), .up_dn(up_dn), .cnt_en_n(cnt_en_n),
    .load_n(load_n), .d(d), .q(q_dec), .term_hit(t_dec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int step(input int m, input int modv, input bit up);
    if (up) return (m >= modv - 1) ? 0 : m + 1;
    return (m == 0) ? modv - 1 : m - 1;
  endfunction

  function automatic int term_of(input int m, input int modv, input bit up);
    if (up) return (m == modv - 1) ? 1 : 0;
    return (m == 0) ? 1 : 0;
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " q bin"}, int'(q_bin), m_bin);
    chk({tag, " q dec"}, int'(q_dec), m_dec);
    chk({tag, " term bin R10"}, int'(t_bin), term_of(m_bin, 16, up_dn));
    chk({tag, " term dec R10"}, int'(t_dec), term_of(m_dec, 10, up_dn));
  endtask

  // One clock: model follows the inputs seen at the rising edge, compare at falling edge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (!load_n) begin
      m_bin = int'(d);
      m_dec = int'(d);
    end else if (!cnt_en_n) begin
      m_bin = step(m_bin, 16, up_dn);
      m_dec = step(m_dec, 10, up_dn);
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; up_dn = 1'b1; cnt_en_n = 1'b0; load_n = 1'b1; d = 4'd0;
    #1;
    chk("R1 reset q bin", int'(q_bin), 0);
    chk("R1 reset q dec", int'(q_dec), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 in reset bin", int'(q_bin), 0);
      chk("R1 in reset dec", int'(q_dec), 0);
    end
    // R1: release; two edges keep 0 even with the enable active
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_all("R1 release edge1");
    @(posedge clk); @(negedge clk);
    check_all("R1 release edge2");
    // R2 R4 R5: up through both wraps
    for (int i = 0; i < 20; i++) tick("R2 R4 R5 up");
    // R7: disabled
    cnt_en_n = 1'b1;
    for (int i = 0; i < 4; i++) tick("R7 hold");
    // R10: direction flip without clock
    up_dn = 1'b0;
    #1;
    check_all("R10 dir flip");
    cnt_en_n = 1'b0;
    // R3 R4 R5: down through both wraps
    for (int i = 0; i < 25; i++) tick("R3 R4 R5 down");
    // R8: asynchronous preset between edges
    load_n = 1'b0; d = 4'd12;
    #1;
    chk("R8 preset bin", int'(q_bin), 12);
    chk("R8 preset dec", int'(q_dec), 12);
    d = 4'd5;
    #1;
    chk("R8 follow bin", int'(q_bin), 5);
    chk("R8 follow dec", int'(q_dec), 5);
    m_bin = 5; m_dec = 5;
    up_dn = 1'b1;
    // R9: preset wins over counting
    for (int i = 0; i < 2; i++) tick("R9 load priority");
    load_n = 1'b1;
    tick("R9 resume");
    chk("R9 resume bin", int'(q_bin), 6);
    // R6: out-of-range preset in decade mode
    load_n = 1'b0; d = 4'd12; cnt_en_n = 1'b1;
    tick("R6 preset 12");
    load_n = 1'b1; cnt_en_n = 1'b0;
    tick("R6 up from 12");
    chk("R6 dec 12 up", int'(q_dec), 0);
    load_n = 1'b0; d = 4'd13; up_dn = 1'b0;
    tick("R6 preset 13");
    load_n = 1'b1;
    tick("R6 down from 13");
    chk("R6 dec 13 down", int'(q_dec), 12);
    // R7 with preset value held
    cnt_en_n = 1'b1;
    for (int i = 0; i < 3; i++) tick("R7 hold after preset");
    // R1: reset asserted during preset wins
    load_n = 1'b0; d = 4'd7;
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 reset over preset bin", int'(q_bin), 0);
    chk("R1 reset over preset dec", int'(q_dec), 0);
    load_n = 1'b1;
    m_bin = 0; m_dec = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick("R1 R7 post reset");
    cnt_en_n = 1'b0; up_dn = 1'b1;
    for (int i = 0; i < 12; i++) tick("R2 R5 final up");
    finish_run();
  end

endmodule